// File: doc/BRIEF.md
# Clock Loss Detector

The block keeps watch over one monitored clock with the help of a reference clock that never stops. It raises an active-high "clock lost" flag once no edge has been seen on the monitored clock for a timeout period. Either edge counts, so a clock that stops high is caught in the same way as one that stops low. There are two timeout lengths, a long one and a short one, and a single select input picks between them. The flag drops within a few reference cycles once edges come back, so it does not wait for any timeout before clearing.

Each monitored clock gets its own instance. The flag can be wired straight to the select input of a glitch-free clock switch. The switch then moves to a backup clock when the primary stops and returns to the primary once it runs again. An enable input holds the flag output low when the flag is not wanted.

The two timeouts are given in picoseconds, together with the reference period. Each one is turned into a terminal count in reference cycles, rounded up: SLOW_TERM = ceil(600 ns / period) and FAST_TERM = ceil(75 ns / period). With the default 10 ns reference these come to 60 and 8. SYNC_STAGES (default 2) sets the depth of the synchronizer. In the requirements below, "cycles" means reference clock cycles.

Top module: `clk_loss_detector`

## Requirements
- R1: While `rst_n` is low, `clk_lost` is low and the timeout counter is zero. If no edge arrives after reset is released, the flag rises SLOW_TERM or SLOW_TERM+1 cycles after release, with `tmo_fast`=0.
- R2: With `tmo_fast`=0, `clk_lost` rises between SLOW_TERM+SYNC_STAGES-1 and SLOW_TERM+SYNC_STAGES+2 cycles after the last monitored edge, and not before.
- R3: With `tmo_fast`=1, `clk_lost` rises between FAST_TERM+SYNC_STAGES-1 and FAST_TERM+SYNC_STAGES+2 cycles after the last monitored edge, and not before.
- R4: A stop is detected in the same way whether the monitored clock is held at 1 or held at 0.
- R5: While the monitored clock runs with edges less than the selected timeout apart, `clk_lost` stays low.
- R6: Once `clk_lost` is high, the first monitored edge clears it within SYNC_STAGES+4 cycles, with no timeout wait.
- R7: While `flag_en`=0, `clk_lost` is 0, yet detection keeps running. Raising `flag_en` while the clock is still stopped shows 1 in the same cycle.
- R8: Switching `tmo_fast` from 0 to 1 during a stop that has already lasted longer than FAST_TERM raises the flag within 2 cycles. Switching it back to 0 does not clear a flag that is already set.
- R9: The counter saturates at the larger terminal count, so a stop of any length keeps `clk_lost` high without wrapping around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored clock |
| tmo_fast | input | 1 | Timeout select: 0 = long (600 ns), 1 = short (75 ns) |
| flag_en | input | 1 | Output enable for the flag; 0 forces `clk_lost` low |
| clk_lost | output | 1 | High when the monitored clock has stopped |

## Verification
If the timeout counter were wrong, the bench would see the flag rise at the wrong cycle after a stop. It can only see this once the whole timeout has run out, which is 8 or 60 cycles later, so the bench measures each rise against a window of a few cycles. If the edge path were wrong, a running clock would raise a false flag, or a restarted clock would fail to clear it within about five cycles. If the flag register were wrong, the flag would fall back while a stop continues or when the select is switched, and the long holds in the bench make this show up at the output.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic {
        TMO_SLOW = 1'b0,
        TMO_FAST = 1'b1
    } tmo_sel_e;

    // Rounded-up number of reference periods that cover a time span.
    function automatic int cycles_for(input int span_ps, input int period_ps);
        return (span_ps + period_ps - 1) / period_ps;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clkmon_edge_sampler.sv
module clkmon_edge_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic activity_o
);
    localparam int NPOL    = 2;             // rising and falling edge
    localparam int CHAIN_W = SYNC_STAGES + 1; // sync stages plus history bit

    typedef struct packed {
        logic [NPOL-1:0][CHAIN_W-1:0] chain;
    } smp_s;

    smp_s            s_d, s_q;
    logic [NPOL-1:0] tgl_w;
    logic [NPOL-1:0] seen;

    // One toggle flop per edge polarity, clocked by the monitored clock.
    for (genvar g = 0; g < NPOL; g++) begin : g_pol
        logic tgl_q;
        if (g == 0) begin : g_rise
            always_ff @(posedge mon_clk or negedge rst_n) begin
                if (!rst_n) tgl_q <= 1'b0;
                else        tgl_q <= ~tgl_q;
            end
        end else begin : g_fall
            always_ff @(negedge mon_clk or negedge rst_n) begin
                if (!rst_n) tgl_q <= 1'b0;
                else        tgl_q <= ~tgl_q;
            end
        end
        assign tgl_w[g] = tgl_q;
        assign seen[g]  = s_q.chain[g][CHAIN_W-1] ^ s_q.chain[g][CHAIN_W-2];
    end

    always_comb begin
        s_d = s_q;
        for (int p = 0; p < NPOL; p++) begin
            s_d.chain[p] = {s_q.chain[p][CHAIN_W-2:0], tgl_w[p]};
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign activity_o = |seen;

endmodule

// File: rtl/clkmon_timer.sv
module clkmon_timer
    import clkmon_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int FAST_TERM = 8,
    parameter int SLOW_TERM = 60
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             activity_i,
    input  logic             tmo_fast_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam int             SAT_TERM = max_of(FAST_TERM, SLOW_TERM);
    localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(SAT_TERM);
    localparam logic [CNT_W-1:0] FAST_C = CNT_W'(FAST_TERM);
    localparam logic [CNT_W-1:0] SLOW_C = CNT_W'(SLOW_TERM);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } tmr_s;

    tmr_s             s_d, s_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        s_d   = s_q;
        limit = (tmo_sel_e'(tmo_fast_i) == TMO_FAST) ? FAST_C : SLOW_C;
        if (activity_i) begin
            s_d.count = '0;
        end else if (s_q.count < SAT_C) begin
            s_d.count = s_q.count + 1'b1;
        end
        expire_o = !activity_i && (s_d.count >= limit);
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;

endmodule

// File: rtl/clkmon_flag.sv
module clkmon_flag (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic activity_i,
    input  logic expire_i,
    input  logic enable_i,
    output logic lost_q_o,
    output logic lost_o
);
    typedef struct packed {
        logic lost;
    } flg_s;

    flg_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (activity_i)    f_d.lost = 1'b0;
        else if (expire_i) f_d.lost = 1'b1;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign lost_q_o = f_q.lost;
    assign lost_o   = f_q.lost & enable_i;

endmodule

// File: rtl/clk_loss_detector.sv
module clk_loss_detector
    import clkmon_pkg::*;
#(
    parameter int REF_PERIOD_PS   = 10000,
    parameter int SLOW_TIMEOUT_PS = 600000,
    parameter int FAST_TIMEOUT_PS = 75000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic tmo_fast,
    input  logic flag_en,
    output logic clk_lost
);
    localparam int SLOW_TERM = cycles_for(SLOW_TIMEOUT_PS, REF_PERIOD_PS);
    localparam int FAST_TERM = cycles_for(FAST_TIMEOUT_PS, REF_PERIOD_PS);
    localparam int SAT_TERM  = max_of(SLOW_TERM, FAST_TERM);
    localparam int CNT_W     = $clog2(SAT_TERM + 1);

    logic             activity;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             lost_q;

    clkmon_edge_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .mon_clk    (mon_clk),
        .activity_o (activity)
    );

    clkmon_timer #(
        .CNT_W     (CNT_W),
        .FAST_TERM (FAST_TERM),
        .SLOW_TERM (SLOW_TERM)
    ) u_timer (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .activity_i (activity),
        .tmo_fast_i (tmo_fast),
        .count_o    (count),
        .expire_o   (expire)
    );

    clkmon_flag u_flag (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .activity_i (activity),
        .expire_i   (expire),
        .enable_i   (flag_en),
        .lost_q_o   (lost_q),
        .lost_o     (clk_lost)
    );

endmodule

// File: rtl/clk_loss_detector_chk.sv
module clk_loss_detector_chk #(
    parameter int CNT_W     = 6,
    parameter int FAST_TERM = 8,
    parameter int SAT_TERM  = 60
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             activity,
    input logic [CNT_W-1:0] count,
    input logic             lost_q,
    input logic             clk_lost
);
    localparam logic [CNT_W-1:0] SAT_C  = CNT_W'(SAT_TERM);
    localparam logic [CNT_W-1:0] FAST_C = CNT_W'(FAST_TERM);

    // R1: reset holds the flag and counter clear
    always @(posedge ref_clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (!clk_lost && count == '0);
        end
    end

    // R2: a quiet cycle advances the counter by exactly one
    assert_count_step_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!activity && count < SAT_C) |=> count == $past(count) + 1'b1);

    // R3: the flag never rises before the shorter terminal count
    assert_no_early_rise_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lost_q) |-> count >= FAST_C);

    // R6: an observed edge clears flag and counter on the next cycle
    assert_edge_clears_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        activity |=> (!lost_q && count == '0));

    // R8: a set flag holds while no edge is seen
    assert_flag_sticky_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (lost_q && !activity) |=> lost_q);

    // R9: the counter never passes its saturation value
    assert_sat_bound_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        count <= SAT_C);

endmodule

bind clk_loss_detector clk_loss_detector_chk #(
    .CNT_W     (CNT_W),
    .FAST_TERM (FAST_TERM),
    .SAT_TERM  (SAT_TERM)
) u_chk (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .activity (activity),
    .count    (count),
    .lost_q   (lost_q),
    .clk_lost (clk_lost)
);

// File: tb/tb_clk_loss_detector.sv
`timescale 1ns/1ps
module tb_clk_loss_detector;
    localparam int CLK_PERIOD = 10;     // ns, matches REF_PERIOD_PS default
    localparam int MON_HALF   = 13;     // ns
    localparam int SYNC       = 2;
    localparam int SLOW_L     = 60;     // ceil(600/10)
    localparam int FAST_L     = 8;      // ceil(75/10)

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic mon_clk = 1'b0;
    logic mon_run = 1'b0;
    logic tmo_fast = 1'b0;
    logic flag_en  = 1'b1;
    logic clk_lost;

    typedef struct {
        string req;
        logic  exp;
        int    lo;
        int    hi;
    } item_t;

    item_t sbq[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    mon_busy = 1'b0;

    clk_loss_detector dut (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .mon_clk  (mon_clk),
        .tmo_fast (tmo_fast),
        .flag_en  (flag_en),
        .clk_lost (clk_lost)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    initial begin
        forever begin
            #(MON_HALF);
            if (mon_run) mon_clk = ~mon_clk;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: %s actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic expect_level(input string req, input logic exp, input int lo, input int hi);
        item_t it;
        it.req = req; it.exp = exp; it.lo = lo; it.hi = hi;
        sbq.push_back(it);
    endtask

    task automatic wait_idle();
        @(negedge ref_clk);
        while (sbq.size() != 0 || mon_busy) @(negedge ref_clk);
    endtask

    task automatic hold_check(input string req, input logic exp, input int n, input string what);
        logic ok;
        ok = 1'b1;
        repeat (n) begin
            @(negedge ref_clk);
            if (clk_lost !== exp) ok = 1'b0;
        end
        check(req, ok, 1'b1, what);
    endtask

    task automatic stop_high();
        @(posedge mon_clk); mon_run = 1'b0;
        @(negedge ref_clk);
    endtask

    task automatic stop_low();
        @(negedge mon_clk); mon_run = 1'b0;
        @(negedge ref_clk);
    endtask

    task automatic restart_clear();
        @(negedge ref_clk);
        mon_run = 1'b1;
        expect_level("R6", 1'b0, 1, SYNC + 4);
        wait_idle();
    endtask

    // Monitor: pops one expectation and counts cycles until the level appears.
    initial begin
        item_t it;
        int    n;
        n = 0;
        forever begin
            @(negedge ref_clk); #1;
            if (!mon_busy && sbq.size() > 0) begin
                it = sbq.pop_front();
                mon_busy = 1'b1;
                n = 0;
            end else if (mon_busy) begin
                n++;
            end
            if (mon_busy) begin
                if (clk_lost === it.exp) begin
                    n_checks++;
                    if (n < it.lo || n > it.hi) begin
                        n_fail++;
                        $display("FAIL %s: level %b after %0d cycles, expected %0d..%0d",
                                 it.req, it.exp, n, it.lo, it.hi);
                    end
                    mon_busy = 1'b0;
                end else if (n > it.hi) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL %s: actual %b after %0d cycles, expected %b by %0d",
                             it.req, clk_lost, n, it.exp, it.hi);
                    mon_busy = 1'b0;
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, then a timeout counted from zero
        repeat (3) @(negedge ref_clk);
        check("R1", clk_lost, 1'b0, "flag during reset");
        @(negedge ref_clk);
        rst_n = 1'b1;
        expect_level("R1", 1'b1, SLOW_L, SLOW_L + 1);
        wait_idle();

        // R6: first restart clears the flag
        restart_clear();

        // R5: running clock, long timeout
        hold_check("R5", 1'b0, 150, "flag while running (slow)");

        // R2 and R4: stuck high, long timeout
        stop_high();
        check("R4", mon_clk, 1'b1, "clock held high");
        expect_level("R2", 1'b1, SLOW_L + SYNC - 1, SLOW_L + SYNC + 2);
        wait_idle();

        // R9: long stop keeps the flag up
        hold_check("R9", 1'b1, 300, "flag over long stop");
        restart_clear();

        // R5: running clock, short timeout
        tmo_fast = 1'b1;
        hold_check("R5", 1'b0, 100, "flag while running (fast)");

        // R3 and R4: stuck low, short timeout
        stop_low();
        check("R4", mon_clk, 1'b0, "clock held low");
        expect_level("R3", 1'b1, FAST_L + SYNC - 1, FAST_L + SYNC + 2);
        wait_idle();

        // R7: enable low forces output low, detection continues
        flag_en = 1'b0;
        #1;
        check("R7", clk_lost, 1'b0, "output with enable low");
        hold_check("R7", 1'b0, 20, "output held low while disabled");
        flag_en = 1'b1;
        #1;
        check("R7", clk_lost, 1'b1, "output after re-enable");
        restart_clear();

        // R8: switch to the short timeout mid-stop, then back
        tmo_fast = 1'b0;
        hold_check("R5", 1'b0, 50, "flag while running (slow again)");
        stop_high();
        hold_check("R2", 1'b0, 20, "no flag before long timeout");
        tmo_fast = 1'b1;
        expect_level("R8", 1'b1, 1, 2);
        wait_idle();
        tmo_fast = 1'b0;
        hold_check("R8", 1'b1, 10, "flag kept after select back to long");
        restart_clear();
        check("R6", clk_lost, 1'b0, "flag after final restart");

        finish_run();
    end

endmodule